// File: doc/BRIEF.md
# Flash Unlock Command Sequencer

This block sits behind the bus front end of a byte-wide flash macro and decides whether a stream of write cycles forms one of the accepted unlock commands. Each write reaches it as a single-cycle strobe with a full byte address and one data byte. It checks every strobe against the next step that it expects. When a command is complete it raises a one-cycle request toward the array controller: enter or leave identification mode, set the lockout on the lower or upper boot block, or erase the whole chip. A program command works differently. It opens a program window that stays open for exactly one program operation.

Every command starts with the same two key writes. The third key write, which is always aimed at the command address, carries the command byte. One command byte leads into a longer form that repeats the two keys and then names the final operation. For boot-block lockout, one last write picks the block through its full address.

A write that breaks a sequence returns the sequencer to idle and raises a dummy-write pulse, which the timer logic downstream uses to run a write cycle that stores nothing. While the array reports a program cycle in progress, the sequencer ignores writes.

Top module: `flash_unlock_seq`

## Requirements
- R1: In reset and in the first cycle after reset, prog_en and all six pulse outputs (id_enter, id_exit, lock_lo, lock_hi, chip_erase, dummy_wr) are low.
- R2: A sequence starts with data 0xAA written to key address 0x5555, followed by data 0x55 written to key address 0x2AAA. Only address bits [14:0] take part in these two key compares and in the command compare.
- R3: After the two keys, a third write to key address 0x5555 with data 0x90 pulses id_enter, and the same write with data 0xF0 pulses id_exit. Either way the sequencer returns to idle.
- R4: A third write to 0x5555 with data 0xA0 sets prog_en high, starting in the cycle after that write.
- R5: While prog_en is high, writes are treated as byte loads. They produce no pulse and do not affect prog_en. prog_en goes low in the cycle after prog_busy falls, and from then on writes must again carry the full key sequence.
- R6: Data 0x80 as the third write leads into the extended form, which needs 0xAA@0x5555 and 0x55@0x2AAA once more. A sixth write to 0x5555 with data ERASE_CODE (default 0x10) then pulses chip_erase.
- R7: A sixth write of data 0x40 to 0x5555 arms lockout. The seventh write must then be data 0x00 to the all-zero full address, which pulses lock_lo, or data 0xFF to the all-ones full address, which pulses lock_hi.
- R8: In idle, any write that is not the first key pulses dummy_wr. Within a sequence, any write that does not match the expected step also pulses dummy_wr, returns the sequencer to idle and raises no operation pulse.
- R9: A write strobe that arrives while prog_busy is high produces no pulse and leaves the progress through a sequence unchanged.
- R10: Each pulse is exactly one cycle wide, appears in the cycle after the strobe that caused it, and at most one pulse output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle write strobe from the bus front end |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| prog_busy | input | 1 | High while the array runs a program cycle |
| prog_en | output | 1 | Program window open (byte loads accepted) |
| id_enter | output | 1 | Pulse: enter identification mode |
| id_exit | output | 1 | Pulse: leave identification mode |
| lock_lo | output | 1 | Pulse: set lockout on the lower boot block |
| lock_hi | output | 1 | Pulse: set lockout on the upper boot block |
| chip_erase | output | 1 | Pulse: erase the whole array |
| dummy_wr | output | 1 | Pulse: unprotected write, run a cycle that stores nothing |

## Verification
The bench uses key writes whose upper address bits are set. A design that compared the full address would answer these with dummy pulses instead of commands. It breaks sequences at the second, fifth and seventh steps, and it sends a lockout target whose data is correct but whose full address is off by one bit; a sequencer that kept its place, or that fired anyway, would show a stray operation pulse. It strobes writes while prog_busy is high, both in the middle of a key sequence and inside the program window; a design that advanced or reset on those writes would lose the command that follows. It also checks that prog_en stays up through byte loads and the busy period and drops only after busy falls.

// File: rtl/unlock_seq_pkg.sv
package unlock_seq_pkg;

   localparam int KEY_W  = 15;
   localparam int DATA_W = 8;

   localparam logic [KEY_W-1:0]  KEY_ADR_CMD = 15'h5555;
   localparam logic [KEY_W-1:0]  KEY_ADR_ALT = 15'h2AAA;
   localparam logic [DATA_W-1:0] KEY_DAT_1   = 8'hAA;
   localparam logic [DATA_W-1:0] KEY_DAT_2   = 8'h55;

   localparam logic [DATA_W-1:0] OP_PROG     = 8'hA0;
   localparam logic [DATA_W-1:0] OP_ID_IN    = 8'h90;
   localparam logic [DATA_W-1:0] OP_ID_OUT   = 8'hF0;
   localparam logic [DATA_W-1:0] OP_EXTEND   = 8'h80;
   localparam logic [DATA_W-1:0] OP_LOCK     = 8'h40;
   localparam logic [DATA_W-1:0] TGT_LOW     = 8'h00;
   localparam logic [DATA_W-1:0] TGT_HIGH    = 8'hFF;

   typedef enum logic [3:0] {
      SQ_IDLE,
      SQ_KEY1,
      SQ_KEY2,
      SQ_EXT0,
      SQ_EXT1,
      SQ_EXT2,
      SQ_LOCK,
      SQ_LOAD
   } seq_state_t;

   typedef struct packed {
      logic erase;
      logic lk_hi;
      logic lk_lo;
      logic id_out;
      logic id_in;
      logic dummy;
   } op_pulse_t;

   localparam int OP_W = $bits(op_pulse_t);

endpackage

// File: rtl/unlock_key_match.sv
module unlock_key_match
   import unlock_seq_pkg::*;
#(
   parameter logic [KEY_W-1:0]  K_ADDR = KEY_ADR_CMD,
   parameter logic [DATA_W-1:0] K_DATA = KEY_DAT_1
) (
   input  logic [KEY_W-1:0]  addr,
   input  logic [DATA_W-1:0] data,
   output logic              addr_hit,
   output logic              data_hit
);

   assign addr_hit = (addr == K_ADDR);
   assign data_hit = (data == K_DATA);

endmodule

// File: rtl/unlock_busy_track.sv
module unlock_busy_track (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   output logic busy_fell
);

   logic busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) busy_q <= 1'b0;
      else        busy_q <= busy;
   end

   assign busy_fell = busy_q & ~busy;

endmodule

// File: rtl/unlock_pulse_reg.sv
module unlock_pulse_reg #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

endmodule

// File: rtl/flash_unlock_seq.sv
module flash_unlock_seq
   import unlock_seq_pkg::*;
#(
   parameter int              ADDR_W     = 20,
   parameter logic [7:0]      ERASE_CODE = 8'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              prog_busy,
   output logic              prog_en,
   output logic              id_enter,
   output logic              id_exit,
   output logic              lock_lo,
   output logic              lock_hi,
   output logic              chip_erase,
   output logic              dummy_wr
);

   // elaboration-time parameter checks
   if (ADDR_W < KEY_W) begin : g_bad_addr_w
      $error("flash_unlock_seq: ADDR_W must be at least KEY_W");
   end
   if (DATA_W != 8) begin : g_bad_data_w
      $error("flash_unlock_seq: command bytes are eight bits wide");
   end
   if (ERASE_CODE == OP_LOCK) begin : g_bad_erase
      $error("flash_unlock_seq: ERASE_CODE collides with the lockout code");
   end

   // key address slice: generate picks the variant
   logic [KEY_W-1:0] key_addr;
   if (ADDR_W == KEY_W) begin : g_key_full
      assign key_addr = wr_addr;
   end else begin : g_key_slice
      assign key_addr = wr_addr[KEY_W-1:0];
   end

   logic at_cmd, dat_k1, at_alt, dat_k2;

   unlock_key_match #(.K_ADDR(KEY_ADR_CMD), .K_DATA(KEY_DAT_1)) u_key_first (
      .addr     (key_addr),
      .data     (wr_data),
      .addr_hit (at_cmd),
      .data_hit (dat_k1)
   );

   unlock_key_match #(.K_ADDR(KEY_ADR_ALT), .K_DATA(KEY_DAT_2)) u_key_second (
      .addr     (key_addr),
      .data     (wr_data),
      .addr_hit (at_alt),
      .data_hit (dat_k2)
   );

   logic tgt_lo_hit, tgt_hi_hit;
   assign tgt_lo_hit = (wr_addr == '0) && (wr_data == TGT_LOW);
   assign tgt_hi_hit = (wr_addr == '1) && (wr_data == TGT_HIGH);

   logic busy_fell;
   unlock_busy_track u_busy (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (prog_busy),
      .busy_fell (busy_fell)
   );

   seq_state_t st_q, st_nx;
   op_pulse_t  op_nx, op_q;
   logic       take;

   assign take = wr_stb & ~prog_busy;

   always_comb begin
      st_nx = st_q;
      op_nx = '0;
      if (st_q == SQ_LOAD) begin
         // byte loads pass through; window closes when the cycle ends
         if (busy_fell) st_nx = SQ_IDLE;
      end else if (take) begin
         unique case (st_q)
            SQ_IDLE: begin
               if (at_cmd && dat_k1) st_nx = SQ_KEY1;
               else                  op_nx.dummy = 1'b1;
            end
            SQ_KEY1: begin
               if (at_alt && dat_k2) st_nx = SQ_KEY2;
               else begin
                  st_nx       = SQ_IDLE;
                  op_nx.dummy = 1'b1;
               end
            end
            SQ_KEY2: begin
               st_nx = SQ_IDLE;
               if (at_cmd && wr_data == OP_PROG)        st_nx        = SQ_LOAD;
               else if (at_cmd && wr_data == OP_ID_IN)  op_nx.id_in  = 1'b1;
               else if (at_cmd && wr_data == OP_ID_OUT) op_nx.id_out = 1'b1;
               else if (at_cmd && wr_data == OP_EXTEND) st_nx        = SQ_EXT0;
               else                                     op_nx.dummy  = 1'b1;
            end
            SQ_EXT0: begin
               if (at_cmd && dat_k1) st_nx = SQ_EXT1;
               else begin
                  st_nx       = SQ_IDLE;
                  op_nx.dummy = 1'b1;
               end
            end
            SQ_EXT1: begin
               if (at_alt && dat_k2) st_nx = SQ_EXT2;
               else begin
                  st_nx       = SQ_IDLE;
                  op_nx.dummy = 1'b1;
               end
            end
            SQ_EXT2: begin
               st_nx = SQ_IDLE;
               if (at_cmd && wr_data == OP_LOCK)          st_nx       = SQ_LOCK;
               else if (at_cmd && wr_data == ERASE_CODE)  op_nx.erase = 1'b1;
               else                                       op_nx.dummy = 1'b1;
            end
            SQ_LOCK: begin
               st_nx = SQ_IDLE;
               if (tgt_lo_hit)      op_nx.lk_lo = 1'b1;
               else if (tgt_hi_hit) op_nx.lk_hi = 1'b1;
               else                 op_nx.dummy = 1'b1;
            end
            default: st_nx = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= SQ_IDLE;
      else        st_q <= st_nx;
   end

   unlock_pulse_reg #(.W(OP_W)) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (op_nx),
      .q     (op_q)
   );

   assign prog_en    = (st_q == SQ_LOAD);
   assign id_enter   = op_q.id_in;
   assign id_exit    = op_q.id_out;
   assign lock_lo    = op_q.lk_lo;
   assign lock_hi    = op_q.lk_hi;
   assign chip_erase = op_q.erase;
   assign dummy_wr   = op_q.dummy;

endmodule

// File: rtl/flash_unlock_seq_chk.sv
module flash_unlock_seq_chk #(
   parameter int         ADDR_W     = 20,
   parameter logic [7:0] ERASE_CODE = 8'h10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_stb,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [7:0]        wr_data,
   input logic              prog_busy,
   input logic              prog_en,
   input logic              id_enter,
   input logic              id_exit,
   input logic              lock_lo,
   input logic              lock_hi,
   input logic              chip_erase,
   input logic              dummy_wr
);

   logic [5:0] pulses;
   assign pulses = {chip_erase, lock_hi, lock_lo, id_exit, id_enter, dummy_wr};

   // R10
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pulses));

   // R10
   pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pulses != 6'b0) |-> $past(wr_stb));

   // R9
   busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_busy |=> (pulses == 6'b0));

   // R3
   id_in_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      id_enter |-> ($past(wr_data) == 8'h90 && $past(wr_addr[14:0]) == 15'h5555));

   // R4
   prog_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_en) |-> ($past(wr_stb) && $past(wr_data) == 8'hA0));

   // R5
   prog_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prog_en) |-> !$past(prog_busy));

   // R6
   erase_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chip_erase |-> ($past(wr_data) == ERASE_CODE));

   // R7
   lock_hi_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_hi |-> ($past(wr_data) == 8'hFF && $past(wr_addr) == {ADDR_W{1'b1}}));

   // R7
   lock_lo_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_lo |-> ($past(wr_data) == 8'h00 && $past(wr_addr) == {ADDR_W{1'b0}}));

endmodule

bind flash_unlock_seq flash_unlock_seq_chk #(.ADDR_W(ADDR_W), .ERASE_CODE(ERASE_CODE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_stb     (wr_stb),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .prog_busy  (prog_busy),
   .prog_en    (prog_en),
   .id_enter   (id_enter),
   .id_exit    (id_exit),
   .lock_lo    (lock_lo),
   .lock_hi    (lock_hi),
   .chip_erase (chip_erase),
   .dummy_wr   (dummy_wr)
);

// File: tb/sim_flash_unlock_seq.sv
module sim_flash_unlock_seq;

   localparam int AW = 20;

   localparam logic [5:0] P_NONE = 6'b000000;
   localparam logic [5:0] P_DUM  = 6'b000001;
   localparam logic [5:0] P_IDIN = 6'b000010;
   localparam logic [5:0] P_IDOT = 6'b000100;
   localparam logic [5:0] P_LO   = 6'b001000;
   localparam logic [5:0] P_HI   = 6'b010000;
   localparam logic [5:0] P_ER   = 6'b100000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_stb = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic          prog_busy = 1'b0;
   logic          prog_en, id_enter, id_exit, lock_lo, lock_hi, chip_erase, dummy_wr;
   logic [5:0]    pulses;

   assign pulses = {chip_erase, lock_hi, lock_lo, id_exit, id_enter, dummy_wr};

   always #2 clk = ~clk;

   flash_unlock_seq #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .prog_busy(prog_busy), .prog_en(prog_en), .id_enter(id_enter), .id_exit(id_exit),
      .lock_lo(lock_lo), .lock_hi(lock_hi), .chip_erase(chip_erase), .dummy_wr(dummy_wr)
   );

   typedef struct {
      logic [5:0] pl;
      logic       pe;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   logic stb_seen = 1'b0;
   logic done = 1'b0;

   always @(posedge clk) stb_seen <= wr_stb;

   // monitor: compare each write's result one cycle after its strobe
   always @(negedge clk) begin
      exp_t e;
      if (rst_n && stb_seen) begin
         n_chk++;
         if (q.size() == 0) begin
            n_fail++;
            $display("FAIL R10 result with no queued write act=%b exp=none", pulses);
         end else begin
            e = q.pop_front();
            if (pulses !== e.pl || prog_en !== e.pe)
               begin
                  n_fail++;
                  $display("FAIL %s act pulses=%b prog_en=%b exp pulses=%b prog_en=%b",
                           e.tag, pulses, prog_en, e.pl, e.pe);
               end
         end
      end else if (rst_n && pulses !== P_NONE) begin
         n_chk++;
         n_fail++;
         $display("FAIL R10 pulse without strobe act=%b exp=%b", pulses, P_NONE);
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                     input logic [5:0] pl, input logic pe, input string tag);
      q.push_back('{pl, pe, tag});
      wr_addr = a;
      wr_data = d;
      wr_stb  = 1'b1;
      @(negedge clk);
      wr_stb  = 1'b0;
      @(negedge clk);
   endtask

   task automatic keys(input string tag);
      wr(20'h05555, 8'hAA, P_NONE, 1'b0, tag);
      wr(20'h02AAA, 8'h55, P_NONE, 1'b0, tag);
   endtask

   task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, expv);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #400000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 outputs low during reset
      chk({prog_en, pulses} == 7'b0, "R1 in reset", {1'b0, prog_en, pulses}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      chk({prog_en, pulses} == 7'b0, "R1 after reset", {1'b0, prog_en, pulses}, 8'h00);

      // R3 identification entry and exit
      keys("R2 key steps");
      wr(20'h05555, 8'h90, P_IDIN, 1'b0, "R3 id_enter");
      keys("R2 key steps");
      wr(20'h05555, 8'hF0, P_IDOT, 1'b0, "R3 id_exit");

      // R2 upper address bits ignored for keys and command
      wr(20'hD5555, 8'hAA, P_NONE, 1'b0, "R2 key1 high bits");
      wr(20'h3AAAA, 8'h55, P_NONE, 1'b0, "R2 key2 high bits");
      wr(20'hF5555, 8'h90, P_IDIN, 1'b0, "R2 command high bits");

      // R8 bare write, broken second key, then command byte alone
      wr(20'h01234, 8'h5A, P_DUM, 1'b0, "R8 bare write");
      wr(20'h05555, 8'hAA, P_NONE, 1'b0, "R8 first key");
      wr(20'h02AAA, 8'h54, P_DUM, 1'b0, "R8 wrong key2 data");
      wr(20'h05555, 8'h90, P_DUM, 1'b0, "R8 back in idle");
      keys("R8 keys");
      wr(20'h05555, 8'h00, P_DUM, 1'b0, "R8 unknown command");
      keys("R8 keys");
      wr(20'h05554, 8'h90, P_DUM, 1'b0, "R8 command wrong address");

      // R6 chip erase
      keys("R6 keys");
      wr(20'h05555, 8'h80, P_NONE, 1'b0, "R6 extend");
      keys("R6 keys again");
      wr(20'h05555, 8'h10, P_ER, 1'b0, "R6 chip_erase");

      // R8 broken fifth step
      keys("R8 keys");
      wr(20'h05555, 8'h80, P_NONE, 1'b0, "R8 extend");
      wr(20'h05555, 8'hAA, P_NONE, 1'b0, "R8 ext key1");
      wr(20'h02AAB, 8'h55, P_DUM, 1'b0, "R8 ext key2 wrong address");

      // R7 lockout low and high
      keys("R7 keys");
      wr(20'h05555, 8'h80, P_NONE, 1'b0, "R7 extend");
      keys("R7 keys again");
      wr(20'h05555, 8'h40, P_NONE, 1'b0, "R7 arm");
      wr(20'h00000, 8'h00, P_LO, 1'b0, "R7 lock_lo");
      keys("R7 keys");
      wr(20'h05555, 8'h80, P_NONE, 1'b0, "R7 extend");
      keys("R7 keys again");
      wr(20'h05555, 8'h40, P_NONE, 1'b0, "R7 arm");
      wr(20'hFFFFF, 8'hFF, P_HI, 1'b0, "R7 lock_hi");
      // R7 target off by one address bit
      keys("R7 keys");
      wr(20'h05555, 8'h80, P_NONE, 1'b0, "R7 extend");
      keys("R7 keys again");
      wr(20'h05555, 8'h40, P_NONE, 1'b0, "R7 arm");
      wr(20'h00001, 8'h00, P_DUM, 1'b0, "R7 bad target");

      // R9 busy write mid-sequence leaves progress unchanged
      keys("R9 keys");
      prog_busy = 1'b1;
      wr(20'h05555, 8'h00, P_NONE, 1'b0, "R9 write while busy");
      prog_busy = 1'b0;
      wr(20'h05555, 8'h90, P_IDIN, 1'b0, "R9 sequence kept");

      // R4/R5 program window
      keys("R4 keys");
      wr(20'h05555, 8'hA0, P_NONE, 1'b1, "R4 prog_en set");
      wr(20'h1230F, 8'h3C, P_NONE, 1'b1, "R5 byte load");
      wr(20'h12300, 8'hAA, P_NONE, 1'b1, "R5 byte load");
      prog_busy = 1'b1;
      @(negedge clk);
      wr(20'h05555, 8'hAA, P_NONE, 1'b1, "R9 ignored in busy window");
      wr(20'h01111, 8'h11, P_NONE, 1'b1, "R5 held while busy");
      prog_busy = 1'b0;
      @(negedge clk);
      chk(prog_en == 1'b0, "R5 prog_en after busy falls", {7'b0, prog_en}, 8'h00);
      wr(20'h1230F, 8'h3C, P_DUM, 1'b0, "R5 protection back");

      repeat (3) @(negedge clk);
      chk(q.size() == 0, "R10 scoreboard drained", q.size(), 8'h00);
      finish_up();
   end

endmodule